// File: doc/BRIEF.md
# Row-Multiplexed Flux Feedback Servo

This block closes one PID feedback loop for every row of a time-multiplexed sensor array. The rows are visited in turn, and each visit delivers one coadded error sample for the current row. The block reads that row's stored integral, previous error and last code. It computes a new 14-bit feedback DAC code and writes the row's state back. One cycle later it presents the code with the row index.

Three modes share the datapath.

- **Plain PID:** the code is the fixed-point sum of the proportional, integral and derivative contributions.
- **Slope-flip:** the sign of the integral contribution follows the parity of a frame counter. The loop can then hold lock on the opposite slope of the sensor response on alternate frames.
- **Ramp:** the loop is bypassed. Each visit adds a programmable step to the row's last code, either wrapping or pinning at full scale.

Any change of the mode select wipes every row's stored state, so a new mode always starts from zero.

Top module: `row_flux_servo`

## Requirements
- R1: While reset is held, out_valid, out_row and out_code are all zero.
- R2: A sample with smp_valid high and an in-range row produces out_valid high on the next clock, with out_row equal to that row. Between outputs, out_row and out_code keep their last values.
- R3: A sample whose row is NUM_ROWS (41) or above produces no output and leaves every row's stored state unchanged.
- R4: In modes 2'b00 (PID) and 2'b01 (slope-flip), the row's integral becomes I' = I + e and the derivative is d = e − e_prev. The code is (kp·e + ki·I' + kd·d) shifted right arithmetically by FRAC_W (6) bits. The gains are two's-complement inputs.
- R5: The stored integral is clamped to ±INT_LIM (100000) after each update.
- R6: The code saturates to 0 when the scaled sum is negative and to 16383 when it exceeds 16383. It never wraps.
- R7: Every row keeps its own integral, previous error and last code. A sample for one row does not alter any other row's state.
- R8: A frame parity bit starts at 0 and toggles on each clock with frame_start high. In mode 2'b01 the integral contribution is negated while the parity is 1. A sample taken in the same cycle as frame_start uses the parity from before the toggle.
- R9: In modes 2'b10 and 2'b11 (ramp) with ramp_sat low, the row's code becomes (last code + ramp_step) mod 16384. Its integral and previous error are not touched.
- R10: In ramp mode with ramp_sat high, a sum above 16383 gives 16383 instead of wrapping.
- R11: Any change of the mode value from the previous clock clears every row's integral, previous error and last code. A sample taken in that same cycle is computed from the cleared state, in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle strobe at each frame boundary; toggles the parity |
| smp_valid | input | 1 | An error sample is present this cycle |
| smp_row | input | ROW_W (6) | Row index of the sample |
| smp_err | input | ERR_W (16) | Signed coadded error |
| mode | input | 2 | 00 PID, 01 slope-flip, 1x ramp |
| kp | input | GAIN_W (12) | Signed proportional gain, FRAC_W fraction bits |
| ki | input | GAIN_W (12) | Signed integral gain |
| kd | input | GAIN_W (12) | Signed derivative gain |
| ramp_step | input | 14 | Ramp increment per visit |
| ramp_sat | input | 1 | 1 pins the ramp at full scale, 0 wraps it |
| out_valid | output | 1 | New code present |
| out_row | output | ROW_W (6) | Row the code belongs to |
| out_code | output | 14 | Feedback DAC code |

## Verification
Three events can land on the same clock edge: a sample, a frame strobe and a mode change.

- **Strobe with sample:** the stimulus raises frame_start together with a slope-flip sample. This shows whether that sample sees the old or the new parity.
- **Mode change with sample:** the stimulus switches the mode in the cycle of a sample. This shows whether that sample computes from cleared state while the other rows are wiped.

A behavioural reference in the bench tracks per-row state with plain integers and is compared with the outputs on every clock. Either wrong ordering therefore shows up as a code mismatch at that visit or at a later one.

// File: rtl/flux_servo_pkg.sv
package flux_servo_pkg;
  localparam int DAC_W = 14;

  typedef enum logic [1:0] {
    SRV_PID   = 2'b00,
    SRV_FLIP  = 2'b01,
    SRV_RAMP  = 2'b10,
    SRV_RAMP2 = 2'b11
  } servo_mode_e;

  function automatic logic is_ramp(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/flux_frame_ctl.sv
module flux_frame_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] mode_in,
  output logic       neg_iterm,
  output logic       mode_chg
);
  import flux_servo_pkg::*;

  logic       par_q, par_d;
  logic [1:0] mode_q, mode_d;

  always_comb begin
    par_d  = par_q;
    mode_d = mode_in;
    if (frame_start) par_d = ~par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q  <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      par_q  <= par_d;
      mode_q <= mode_d;
    end
  end

  assign mode_chg  = (mode_in != mode_q);
  assign neg_iterm = par_q && (mode_in == SRV_FLIP);
endmodule

// File: rtl/flux_row_store.sv
module flux_row_store #(
  parameter int NUM_ROWS = 41,
  parameter int ROW_W    = 6,
  parameter int ERR_W    = 16,
  parameter int INT_W    = 20,
  parameter int DAC_W    = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_all,
  input  logic                    wr_en,
  input  logic                    wr_pid,
  input  logic [ROW_W-1:0]        wr_row,
  input  logic signed [INT_W-1:0] wr_integ,
  input  logic signed [ERR_W-1:0] wr_prev,
  input  logic [DAC_W-1:0]        wr_code,
  input  logic [ROW_W-1:0]        rd_row,
  output logic signed [INT_W-1:0] rd_integ,
  output logic signed [ERR_W-1:0] rd_prev,
  output logic [DAC_W-1:0]        rd_code
);
  logic signed [INT_W-1:0] integ_all [NUM_ROWS];
  logic signed [ERR_W-1:0] prev_all  [NUM_ROWS];
  logic [DAC_W-1:0]        code_all  [NUM_ROWS];

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic signed [INT_W-1:0] integ_q, integ_d;
    logic signed [ERR_W-1:0] prev_q, prev_d;
    logic [DAC_W-1:0]        code_q, code_d;
    logic                    hit, row_en;

    assign hit    = wr_en && (wr_row == ROW_W'(i));
    assign row_en = hit || clr_all;

    always_comb begin
      integ_d = integ_q;
      prev_d  = prev_q;
      code_d  = code_q;
      if (clr_all) begin
        integ_d = '0;
        prev_d  = '0;
        code_d  = '0;
      end
      if (hit) begin
        code_d = wr_code;
        if (wr_pid) begin
          integ_d = wr_integ;
          prev_d  = wr_prev;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        integ_q <= '0;
        prev_q  <= '0;
        code_q  <= '0;
      end else if (row_en) begin
        integ_q <= integ_d;
        prev_q  <= prev_d;
        code_q  <= code_d;
      end
    end

    assign integ_all[i] = integ_q;
    assign prev_all[i]  = prev_q;
    assign code_all[i]  = code_q;
  end

  always_comb begin
    rd_integ = '0;
    rd_prev  = '0;
    rd_code  = '0;
    if (!clr_all) begin
      for (int k = 0; k < NUM_ROWS; k++) begin
        if (rd_row == ROW_W'(k)) begin
          rd_integ = integ_all[k];
          rd_prev  = prev_all[k];
          rd_code  = code_all[k];
        end
      end
    end
  end
endmodule

// File: rtl/flux_pid_math.sv
module flux_pid_math #(
  parameter int ERR_W   = 16,
  parameter int GAIN_W  = 12,
  parameter int FRAC_W  = 6,
  parameter int INT_W   = 20,
  parameter int INT_LIM = 100000,
  parameter int DAC_W   = 14
) (
  input  logic signed [ERR_W-1:0]  err,
  input  logic signed [INT_W-1:0]  integ_old,
  input  logic signed [ERR_W-1:0]  prev_old,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [GAIN_W-1:0] kd,
  input  logic                     neg_iterm,
  output logic signed [INT_W-1:0]  integ_new,
  output logic [DAC_W-1:0]         code
);
  localparam int ACC_W = GAIN_W + INT_W + 2;
  localparam logic signed [INT_W:0]   LIM_P   = (INT_W+1)'(INT_LIM);
  localparam logic signed [INT_W:0]   LIM_N   = -LIM_P;
  localparam logic signed [ACC_W-1:0] DAC_TOP = ACC_W'((1 << DAC_W) - 1);

  logic signed [INT_W:0]   isum;
  logic signed [ACC_W-1:0] e_x, i_x, d_x, kp_x, ki_x, kd_x;
  logic signed [ACC_W-1:0] p_term, i_term, d_term, acc, scaled;

  always_comb begin
    isum = (INT_W+1)'(integ_old) + (INT_W+1)'(err);
    if (isum > LIM_P)      integ_new = INT_W'(LIM_P);
    else if (isum < LIM_N) integ_new = INT_W'(LIM_N);
    else                   integ_new = INT_W'(isum);
  end

  always_comb begin
    e_x  = ACC_W'(err);
    i_x  = ACC_W'(integ_new);
    d_x  = ACC_W'(err) - ACC_W'(prev_old);
    kp_x = ACC_W'(kp);
    ki_x = ACC_W'(ki);
    kd_x = ACC_W'(kd);
    p_term = kp_x * e_x;
    i_term = ki_x * i_x;
    if (neg_iterm) i_term = -i_term;
    d_term = kd_x * d_x;
    acc    = p_term + i_term + d_term;
    scaled = acc >>> FRAC_W;
    if (scaled < 0)            code = '0;
    else if (scaled > DAC_TOP) code = '1;
    else                       code = DAC_W'(scaled);
  end
endmodule

// File: rtl/flux_ramp_step.sv
module flux_ramp_step #(
  parameter int DAC_W = 14
) (
  input  logic [DAC_W-1:0] code_old,
  input  logic [DAC_W-1:0] step,
  input  logic             sat,
  output logic [DAC_W-1:0] code_new
);
  logic [DAC_W:0] sum;

  always_comb begin
    sum = {1'b0, code_old} + {1'b0, step};
    if (sat && sum[DAC_W]) code_new = '1;
    else                   code_new = sum[DAC_W-1:0];
  end
endmodule

// File: rtl/row_flux_servo.sv
module row_flux_servo #(
  parameter int NUM_ROWS = 41,
  parameter int ROW_W    = $clog2(NUM_ROWS),
  parameter int ERR_W    = 16,
  parameter int GAIN_W   = 12,
  parameter int FRAC_W   = 6,
  parameter int INT_W    = 20,
  parameter int INT_LIM  = 100000,
  parameter int DAC_W    = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     smp_valid,
  input  logic [ROW_W-1:0]         smp_row,
  input  logic signed [ERR_W-1:0]  smp_err,
  input  logic [1:0]               mode,
  input  logic signed [GAIN_W-1:0] kp,
  input  logic signed [GAIN_W-1:0] ki,
  input  logic signed [GAIN_W-1:0] kd,
  input  logic [DAC_W-1:0]         ramp_step,
  input  logic                     ramp_sat,
  output logic                     out_valid,
  output logic [ROW_W-1:0]         out_row,
  output logic [DAC_W-1:0]         out_code
);
  import flux_servo_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic neg_iterm, mode_chg, in_range, take, ramp_on;
  logic signed [INT_W-1:0] rd_integ, integ_new;
  logic signed [ERR_W-1:0] rd_prev;
  logic [DAC_W-1:0]        rd_code, pid_code, ramp_code, new_code;

  assign in_range = ({1'b0, smp_row} < (ROW_W+1)'(NUM_ROWS));
  assign take     = smp_valid && in_range;
  assign ramp_on  = is_ramp(mode);
  assign new_code = ramp_on ? ramp_code : pid_code;

  flux_frame_ctl u_frame (
    .clk         (clk),
    .rst_n       (rst_i),
    .frame_start (frame_start),
    .mode_in     (mode),
    .neg_iterm   (neg_iterm),
    .mode_chg    (mode_chg)
  );

  flux_row_store #(
    .NUM_ROWS (NUM_ROWS), .ROW_W (ROW_W), .ERR_W (ERR_W),
    .INT_W (INT_W), .DAC_W (DAC_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr_all  (mode_chg),
    .wr_en    (take),
    .wr_pid   (!ramp_on),
    .wr_row   (smp_row),
    .wr_integ (integ_new),
    .wr_prev  (smp_err),
    .wr_code  (new_code),
    .rd_row   (smp_row),
    .rd_integ (rd_integ),
    .rd_prev  (rd_prev),
    .rd_code  (rd_code)
  );

  flux_pid_math #(
    .ERR_W (ERR_W), .GAIN_W (GAIN_W), .FRAC_W (FRAC_W),
    .INT_W (INT_W), .INT_LIM (INT_LIM), .DAC_W (DAC_W)
  ) u_pid (
    .err       (smp_err),
    .integ_old (rd_integ),
    .prev_old  (rd_prev),
    .kp        (kp),
    .ki        (ki),
    .kd        (kd),
    .neg_iterm (neg_iterm),
    .integ_new (integ_new),
    .code      (pid_code)
  );

  flux_ramp_step #(.DAC_W (DAC_W)) u_ramp (
    .code_old (rd_code),
    .step     (ramp_step),
    .sat      (ramp_sat),
    .code_new (ramp_code)
  );

  logic             vld_d;
  logic [ROW_W-1:0] row_d;
  logic [DAC_W-1:0] code_d;

  always_comb begin
    vld_d  = take;
    row_d  = out_row;
    code_d = out_code;
    if (take) begin
      row_d  = smp_row;
      code_d = new_code;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_code  <= '0;
    end else begin
      out_valid <= vld_d;
      if (take) begin
        out_row  <= row_d;
        out_code <= code_d;
      end
    end
  end
endmodule

// File: rtl/flux_servo_chk.sv
module flux_servo_chk #(
  parameter int NUM_ROWS = 41,
  parameter int ROW_W    = 6,
  parameter int DAC_W    = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [ROW_W-1:0] smp_row,
  input logic             out_valid,
  input logic [ROW_W-1:0] out_row,
  input logic [DAC_W-1:0] out_code
);
  assert_out_follows_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_valid));

  assert_row_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_row == $past(smp_row)));

  assert_outputs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_code) && $stable(out_row)));

  assert_bad_row_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ({1'b0, smp_row} >= (ROW_W+1)'(NUM_ROWS))) |=> !out_valid);

  always_comb begin
    if (rst_n === 1'b0) begin
      assert_reset_quiet_R1: assert (out_valid !== 1'b1);
    end
  end
endmodule

bind row_flux_servo flux_servo_chk #(
  .NUM_ROWS (NUM_ROWS), .ROW_W (ROW_W), .DAC_W (DAC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_row   (smp_row),
  .out_valid (out_valid),
  .out_row   (out_row),
  .out_code  (out_code)
);

// File: tb/row_flux_servo_test.sv
module row_flux_servo_test;
  localparam int ROWS = 41;
  localparam int LIM  = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic smp_valid = 1'b0;
  logic [5:0] smp_row = '0;
  logic signed [15:0] smp_err = '0;
  logic [1:0] mode = 2'b00;
  logic signed [11:0] kp = '0, ki = '0, kd = '0;
  logic [13:0] ramp_step = '0;
  logic ramp_sat = 1'b0;
  logic out_valid;
  logic [5:0] out_row;
  logic [13:0] out_code;

  always #4 clk = ~clk;

  row_flux_servo uut (
    .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
    .smp_valid (smp_valid), .smp_row (smp_row), .smp_err (smp_err),
    .mode (mode), .kp (kp), .ki (ki), .kd (kd),
    .ramp_step (ramp_step), .ramp_sat (ramp_sat),
    .out_valid (out_valid), .out_row (out_row), .out_code (out_code)
  );

  int total = 0;
  int bad = 0;
  bit model_on = 0;
  bit finished = 0;
  string cur_req = "R1";

  longint m_int [ROWS];
  longint m_prev [ROWS];
  longint m_code [ROWS];
  bit     m_par;
  logic [1:0] m_mode;
  bit     e_valid;
  int     e_row;
  longint e_code;

  always @(posedge clk) begin
    if (!model_on) begin
      for (int r = 0; r < ROWS; r++) begin
        m_int[r] = 0; m_prev[r] = 0; m_code[r] = 0;
      end
      m_par = 0; m_mode = 2'b00; e_valid = 0; e_row = 0; e_code = 0;
    end else begin
      longint e, i, d, it, acc, s, n;
      int r;
      if (mode != m_mode) begin
        for (int q = 0; q < ROWS; q++) begin
          m_int[q] = 0; m_prev[q] = 0; m_code[q] = 0;
        end
      end
      e_valid = 0;
      if (smp_valid && int'(smp_row) < ROWS) begin
        r = int'(smp_row);
        e_valid = 1;
        e_row = r;
        if (mode[1]) begin
          n = m_code[r] + longint'(ramp_step);
          if (n > 16383) n = ramp_sat ? 16383 : n - 16384;
          m_code[r] = n;
          e_code = n;
        end else begin
          e = longint'(smp_err);
          i = m_int[r] + e;
          if (i > LIM) i = LIM;
          if (i < -LIM) i = -LIM;
          d = e - m_prev[r];
          it = longint'(ki) * i;
          if (mode == 2'b01 && m_par) it = -it;
          acc = longint'(kp) * e + it + longint'(kd) * d;
          s = acc >>> 6;
          if (s < 0) s = 0;
          if (s > 16383) s = 16383;
          m_int[r] = i; m_prev[r] = e; m_code[r] = s;
          e_code = s;
        end
      end
      if (frame_start) m_par = !m_par;
      m_mode = mode;
    end
  end

  always @(negedge clk) begin
    if (model_on && !finished) begin
      total++;
      if (out_valid !== e_valid) begin
        bad++;
        $display("FAIL %s valid: got %0b expected %0b", cur_req, out_valid, e_valid);
      end
      if (e_valid) begin
        total++;
        if (int'(out_row) != e_row) begin
          bad++;
          $display("FAIL %s row: got %0d expected %0d", cur_req, out_row, e_row);
        end
      end
      total++;
      if (longint'(out_code) != e_code) begin
        bad++;
        $display("FAIL %s code: got %0d expected %0d", cur_req, out_code, e_code);
      end
    end
  end

  task automatic put(input bit v, input int row, input int err, input bit fs);
    smp_valid   = v;
    smp_row     = 6'(row);
    smp_err     = 16'(err);
    frame_start = fs;
    @(negedge clk);
    smp_valid   = 1'b0;
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    total++;
    if (out_valid !== 1'b0 || out_code !== 14'd0 || out_row !== 6'd0) begin
      bad++;
      $display("FAIL R1 reset: got v=%0b row=%0d code=%0d expected 0 0 0",
               out_valid, out_row, out_code);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    cur_req = "R2 R4";
    kp = 12'sd64; ki = 12'sd16; kd = 12'sd32;
    put(1, 0, 100, 0);
    put(1, 1, -50, 0);
    put(0, 0, 0, 0);
    put(1, 0, 200, 0);
    put(1, 40, 1000, 0);
    put(0, 0, 0, 0);

    cur_req = "R7";
    for (int f = 0; f < 3; f++)
      for (int r = 0; r < 6; r++) put(1, r, r * 37 - 60 + f * 11, 0);

    cur_req = "R3";
    put(1, 41, 5000, 0);
    put(1, 63, -3000, 0);
    put(1, 0, 10, 0);
    put(1, 40, -20, 0);

    cur_req = "R5";
    kp = 12'sd0; ki = 12'sd1; kd = 12'sd0;
    for (int k = 0; k < 5; k++) put(1, 2, 32767, 0);
    for (int k = 0; k < 2; k++) put(1, 2, -32768, 0);

    cur_req = "R6";
    kp = 12'sd2047; ki = 12'sd0; kd = 12'sd0;
    put(1, 3, 20000, 0);
    put(1, 3, -20000, 0);
    kp = -12'sd2048;
    put(1, 3, -9000, 0);

    cur_req = "R8";
    mode = 2'b01;
    kp = 12'sd32; ki = 12'sd64; kd = 12'sd0;
    for (int f = 0; f < 6; f++) begin
      put(1, 4, 300, 0);
      put(1, 5, -120, 0);
      put(1, 6, 50, 1);
    end

    cur_req = "R11";
    mode = 2'b00;
    put(1, 4, 70, 0);
    put(1, 5, 70, 0);
    put(1, 6, -5, 0);

    cur_req = "R9";
    mode = 2'b10;
    ramp_step = 14'd3000; ramp_sat = 1'b0;
    for (int k = 0; k < 7; k++) begin
      put(1, 7, 0, 0);
      put(1, 8, 0, k[0]);
    end

    cur_req = "R10";
    ramp_sat = 1'b1;
    for (int k = 0; k < 7; k++) put(1, 7, 0, 0);

    cur_req = "R11";
    mode = 2'b11;
    put(1, 7, 0, 0);
    put(1, 8, 0, 0);
    mode = 2'b00;
    kp = 12'sd64; ki = 12'sd16; kd = 12'sd32;
    put(0, 0, 0, 0);
    put(1, 0, 500, 0);
    put(1, 2, -100, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule